// File: doc/BRIEF.md
# Shared-Diffusion Rolling Readout Sequencer

This block drives the control strobes of a pinned-photodiode array in which a group of photodiodes shares one floating diffusion, one reset device and one row-select path. After a start request it walks the array row by row in ascending order. Inside each row it walks the shared photodiodes one after another, so the integration windows of successive rows are staggered by one row readout time and the array has a scrolling shutter.

For every photodiode it runs a fixed four-phase sequence. The reset phase selects the row, raises the reset strobe and drives the column line high, which clears the diffusion before the charge is read. The transfer phase opens exactly one transfer gate. A one-cycle sample strobe then lets the column storage stage capture the level. The park phase closes the gate and keeps the row selected while the column line is driven low, so the diffusion is left low and that follower stays off the column until its row is selected again. The lengths of the reset, transfer and park phases are cycle counts set by inputs.

In the optional snapshot mode the block first opens every transfer gate of the array together for one global transfer. It then reads the rows in the same scrolling order with only the sample and park phases.

Top module: `ssq_rolling_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done`, `pix_rst`, `col_hi`, `col_lo`, `col_smp`, `snap_all`, `row_sel` and `tx` are all low.
- R2: A `start` sampled high while idle makes `busy` high on the next cycle, and the first phase is visible on that cycle. A `start` sampled while `busy` is high has no effect on any output.
- R3: In normal mode each photodiode gets, in this order: a reset phase (`pix_rst` and `col_hi` high) lasting max(`len_rst`,1) cycles; a transfer phase (only bit `sub_idx` of `tx` high) lasting max(`len_tx`,1) cycles; one cycle with `col_smp` high; a park phase (`col_lo` high) lasting max(`len_park`,1) cycles. A length of zero is treated as one cycle.
- R4: Photodiodes are visited as sub-index 0 up to SUBS-1 within a row, and rows from 0 up to ROWS-1. While busy, `row_idx` and `sub_idx` give the row and photodiode being served.
- R5: During every reset, transfer, sample and park cycle, `row_sel` is one-hot with bit `row_idx` set. At all other times it is zero.
- R6: Outside the global transfer, at most one `tx` bit is high. No `tx` bit is ever high while `col_hi` is high.
- R7: `col_hi` and `col_lo` are never high together, and `pix_rst` is high only while `col_hi` is high.
- R8: One cycle after the last park cycle of photodiode SUBS-1 of row ROWS-1, `done` is high for exactly one cycle with all other strobes low. The block is idle on the following cycle.
- R9: When `snap_mode` is high at start, the block first holds `snap_all` high and all `tx` bits high, with `row_sel` zero, for max(`len_tx`,1) cycles. Then each photodiode in the R4 order gets one `col_smp` cycle followed by the park phase, with no reset phase and no transfer phase.
- R10: The mode and the three lengths are captured when the start is accepted. Changing them while busy does not alter the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame request, accepted only while idle |
| snap_mode | input | 1 | Selects the global-transfer frame at start |
| len_rst | input | LEN_W | Reset phase length in cycles (0 is treated as 1) |
| len_tx | input | LEN_W | Transfer phase length, also the global transfer length |
| len_park | input | LEN_W | Park phase length in cycles |
| row_sel | output | ROWS | One-hot row select |
| pix_rst | output | 1 | Diffusion reset strobe |
| tx | output | SUBS | Transfer-gate strobes, one per shared photodiode |
| col_hi | output | 1 | Drive the column line high |
| col_lo | output | 1 | Drive the column line low |
| col_smp | output | 1 | Column storage sample strobe |
| snap_all | output | 1 | Global transfer in progress |
| done | output | 1 | Frame finished pulse |
| busy | output | 1 | Frame in progress |
| row_idx | output | RW | Row being served |
| sub_idx | output | SW | Photodiode being served within the row |

## Verification
Every output comes from registered phase, counter and index state, so the first phase of a frame is due one clock edge after the edge that samples `start`. Each later cycle of the frame follows directly from the captured lengths. The driver computes the whole per-cycle output sequence from the requirements, starting with the one idle cycle before the capturing edge, and queues it when it raises `start`. The monitor takes one entry per falling edge and compares it, so each expected value is checked half a cycle after the edge that produced it. A start pulse and changed lengths injected in the middle of a frame leave the queued sequence unchanged, which checks that they are ignored.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  parameter int LEN_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SNAP,
    PH_RST,
    PH_TX,
    PH_SMP,
    PH_PARK,
    PH_DONE
  } phase_e;

  // A programmed length of zero still occupies one cycle.
  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] v);
    return (v == '0) ? LEN_W'(1) : v;
  endfunction

  // True for the phases in which one row is selected.
  function automatic logic row_phase(input phase_e p);
    return (p == PH_RST) || (p == PH_TX) || (p == PH_SMP) || (p == PH_PARK);
  endfunction
endpackage

// File: rtl/ssq_phase_timer.sv
module ssq_phase_timer
  import ssq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_len - LEN_W'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - LEN_W'(1);
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/ssq_index.sv
module ssq_index #(
  parameter int ROWS = 6,
  parameter int SUBS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SW = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [RW-1:0] row,
  output logic [SW-1:0] sub,
  output logic          last_row,
  output logic          last_sub
);
  assign last_row = (row == RW'(ROWS - 1));
  assign last_sub = (sub == SW'(SUBS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      sub <= '0;
    end else if (clear) begin
      row <= '0;
      sub <= '0;
    end else if (step) begin
      if (last_sub) begin
        sub <= '0;
        row <= row + RW'(1);
      end else begin
        sub <= sub + SW'(1);
      end
    end
  end
endmodule

// File: rtl/ssq_decode.sv
module ssq_decode
  import ssq_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int SUBS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SW = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  phase_e          ph,
  input  logic [RW-1:0]   row,
  input  logic [SW-1:0]   sub,
  output logic [ROWS-1:0] row_sel,
  output logic [SUBS-1:0] tx,
  output logic            pix_rst,
  output logic            col_hi,
  output logic            col_lo,
  output logic            col_smp,
  output logic            snap_all,
  output logic            done
);
  logic in_row;
  assign in_row = row_phase(ph);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel[r] = in_row && (row == RW'(r));
  end

  for (genvar s = 0; s < SUBS; s++) begin : g_tx
    assign tx[s] = (ph == PH_SNAP) || ((ph == PH_TX) && (sub == SW'(s)));
  end

  assign pix_rst  = (ph == PH_RST);
  assign col_hi   = (ph == PH_RST);
  assign col_lo   = (ph == PH_PARK);
  assign col_smp  = (ph == PH_SMP);
  assign snap_all = (ph == PH_SNAP);
  assign done     = (ph == PH_DONE);
endmodule

// File: rtl/ssq_rolling_seq.sv
module ssq_rolling_seq
  import ssq_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int SUBS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SW = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             snap_mode,
  input  logic [LEN_W-1:0] len_rst,
  input  logic [LEN_W-1:0] len_tx,
  input  logic [LEN_W-1:0] len_park,
  output logic [ROWS-1:0]  row_sel,
  output logic             pix_rst,
  output logic [SUBS-1:0]  tx,
  output logic             col_hi,
  output logic             col_lo,
  output logic             col_smp,
  output logic             snap_all,
  output logic             done,
  output logic             busy,
  output logic [RW-1:0]    row_idx,
  output logic [SW-1:0]    sub_idx
);
  phase_e           ph_q, ph_d;
  logic [LEN_W-1:0] lr_q, lt_q, lp_q;
  logic             snap_q;
  logic             accept;
  logic             tmr_load, tmr_last;
  logic [LEN_W-1:0] tmr_len;
  logic             idx_step, last_row, last_sub;

  // Named internal events used by the checker.
  assign accept = (ph_q == PH_IDLE) && start;
  assign busy   = (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      lr_q   <= LEN_W'(1);
      lt_q   <= LEN_W'(1);
      lp_q   <= LEN_W'(1);
      snap_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        lr_q   <= eff_len(len_rst);
        lt_q   <= eff_len(len_tx);
        lp_q   <= eff_len(len_park);
        snap_q <= snap_mode;
      end
    end
  end

  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_len  = LEN_W'(1);
    idx_step = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        tmr_load = 1'b1;
        if (snap_mode) begin
          ph_d    = PH_SNAP;
          tmr_len = eff_len(len_tx);
        end else begin
          ph_d    = PH_RST;
          tmr_len = eff_len(len_rst);
        end
      end
      PH_SNAP: if (tmr_last) begin
        ph_d     = PH_SMP;
        tmr_load = 1'b1;
      end
      PH_RST: if (tmr_last) begin
        ph_d     = PH_TX;
        tmr_load = 1'b1;
        tmr_len  = lt_q;
      end
      PH_TX: if (tmr_last) begin
        ph_d     = PH_SMP;
        tmr_load = 1'b1;
      end
      PH_SMP: if (tmr_last) begin
        ph_d     = PH_PARK;
        tmr_load = 1'b1;
        tmr_len  = lp_q;
      end
      PH_PARK: if (tmr_last) begin
        if (last_row && last_sub) begin
          ph_d = PH_DONE;
        end else begin
          idx_step = 1'b1;
          tmr_load = 1'b1;
          if (snap_q) begin
            ph_d = PH_SMP;
          end else begin
            ph_d    = PH_RST;
            tmr_len = lr_q;
          end
        end
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  ssq_phase_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .last     (tmr_last)
  );

  ssq_index #(.ROWS(ROWS), .SUBS(SUBS)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .step     (idx_step),
    .row      (row_idx),
    .sub      (sub_idx),
    .last_row (last_row),
    .last_sub (last_sub)
  );

  ssq_decode #(.ROWS(ROWS), .SUBS(SUBS)) u_decode (
    .ph       (ph_q),
    .row      (row_idx),
    .sub      (sub_idx),
    .row_sel  (row_sel),
    .tx       (tx),
    .pix_rst  (pix_rst),
    .col_hi   (col_hi),
    .col_lo   (col_lo),
    .col_smp  (col_smp),
    .snap_all (snap_all),
    .done     (done)
  );
endmodule

// File: rtl/ssq_rolling_seq_chk.sv
module ssq_rolling_seq_chk #(
  parameter int ROWS = 6,
  parameter int SUBS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            busy,
  input logic            done,
  input logic [ROWS-1:0] row_sel,
  input logic [SUBS-1:0] tx,
  input logic            pix_rst,
  input logic            col_hi,
  input logic            col_lo,
  input logic            col_smp,
  input logic            snap_all
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (row_sel == '0) && (tx == '0) && !col_hi && !col_lo && !col_smp && !done);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_smp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col_smp |=> !col_smp);

  p_row_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  p_row_when_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_hi || col_lo || col_smp) |-> $countones(row_sel) == 1);

  p_tx_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_all |-> $onehot0(tx));

  p_tx_not_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    col_hi |-> (tx == '0));

  p_col_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(col_hi && col_lo));

  p_rst_with_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rst |-> col_hi);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_snap_rowsel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snap_all |-> (row_sel == '0) && (tx == '1));
endmodule

bind ssq_rolling_seq ssq_rolling_seq_chk #(.ROWS(ROWS), .SUBS(SUBS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .busy     (busy),
  .done     (done),
  .row_sel  (row_sel),
  .tx       (tx),
  .pix_rst  (pix_rst),
  .col_hi   (col_hi),
  .col_lo   (col_lo),
  .col_smp  (col_smp),
  .snap_all (snap_all)
);

// File: tb/test_ssq_rolling_seq.sv
module test_ssq_rolling_seq;
  import ssq_pkg::*;
  localparam int ROWS = 6;
  localparam int SUBS = 4;
  localparam int RW = $clog2(ROWS);
  localparam int SW = $clog2(SUBS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             snap_mode = 1'b0;
  logic [LEN_W-1:0] len_rst = '0, len_tx = '0, len_park = '0;
  logic [ROWS-1:0]  row_sel;
  logic [SUBS-1:0]  tx;
  logic             pix_rst, col_hi, col_lo, col_smp, snap_all, done, busy;
  logic [RW-1:0]    row_idx;
  logic [SW-1:0]    sub_idx;

  always #2 clk = ~clk;

  ssq_rolling_seq #(.ROWS(ROWS), .SUBS(SUBS)) i_ssq_rolling_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .snap_mode(snap_mode),
    .len_rst(len_rst), .len_tx(len_tx), .len_park(len_park),
    .row_sel(row_sel), .pix_rst(pix_rst), .tx(tx), .col_hi(col_hi),
    .col_lo(col_lo), .col_smp(col_smp), .snap_all(snap_all), .done(done),
    .busy(busy), .row_idx(row_idx), .sub_idx(sub_idx)
  );

  typedef struct {
    logic [ROWS-1:0] rs;
    logic [SUBS-1:0] tx;
    logic [5:0]      ctl;  // {pix_rst, col_hi, col_lo, col_smp, snap_all, done}
    logic            bz;
    int              r;
    int              s;
    string           tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  function automatic exp_t mk(input logic [ROWS-1:0] rs, input logic [SUBS-1:0] t,
                              input logic [5:0] ctl, input logic bz, input int r,
                              input int s, input string tag);
    exp_t e;
    e.rs = rs; e.tx = t; e.ctl = ctl; e.bz = bz; e.r = r; e.s = s; e.tag = tag;
    return e;
  endfunction

  function automatic int clamp(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Monitor: one expected entry per falling edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [5:0] act_ctl;
      e = q.pop_front();
      act_ctl = {pix_rst, col_hi, col_lo, col_smp, snap_all, done};
      n_chk++;
      if (row_sel !== e.rs || tx !== e.tx || act_ctl !== e.ctl || busy !== e.bz ||
          (e.bz && (int'(row_idx) != e.r || int'(sub_idx) != e.s))) begin
        n_bad++;
        $display("FAIL %s: got rs=%b tx=%b ctl=%b busy=%b idx=%0d/%0d exp rs=%b tx=%b ctl=%b busy=%b idx=%0d/%0d",
                 e.tag, row_sel, tx, act_ctl, busy, row_idx, sub_idx,
                 e.rs, e.tx, e.ctl, e.bz, e.r, e.s);
      end
    end
  end

  // Driver: raises start and queues the whole expected frame.
  task automatic run_frame(input bit snap, input int lr, input int lt, input int lp,
                           input bit glitch, input string tag);
    int er, et, ep;
    er = clamp(lr); et = clamp(lt); ep = clamp(lp);
    @(posedge clk); #1;
    snap_mode = snap;
    len_rst = LEN_W'(lr); len_tx = LEN_W'(lt); len_park = LEN_W'(lp);
    start = 1'b1;
    q.push_back(mk('0, '0, 6'b000000, 1'b0, 0, 0, tag));  // before capture edge
    if (snap)
      for (int i = 0; i < et; i++) q.push_back(mk('0, '1, 6'b000010, 1'b1, 0, 0, tag));
    for (int r = 0; r < ROWS; r++) begin
      for (int s = 0; s < SUBS; s++) begin
        logic [ROWS-1:0] rs;
        rs = ROWS'(1) << r;
        if (!snap) begin
          for (int i = 0; i < er; i++) q.push_back(mk(rs, '0, 6'b110000, 1'b1, r, s, tag));
          for (int i = 0; i < et; i++) q.push_back(mk(rs, SUBS'(1) << s, 6'b000000, 1'b1, r, s, tag));
        end
        q.push_back(mk(rs, '0, 6'b000100, 1'b1, r, s, tag));
        for (int i = 0; i < ep; i++) q.push_back(mk(rs, '0, 6'b001000, 1'b1, r, s, tag));
      end
    end
    q.push_back(mk('0, '0, 6'b000001, 1'b1, ROWS - 1, SUBS - 1, tag));
    q.push_back(mk('0, '0, 6'b000000, 1'b0, 0, 0, tag));
    @(posedge clk); #1;
    start = 1'b0;
    if (glitch) begin
      // R2 / R10: a second start and new settings while busy must change nothing.
      repeat (20) @(posedge clk);
      #1;
      start = 1'b1; snap_mode = ~snap; len_rst = 8'd9; len_tx = 8'd0; len_park = 8'd7;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    n_chk++;
    if (busy !== 1'b0 || done !== 1'b0 || row_sel !== '0 || tx !== '0 ||
        {pix_rst, col_hi, col_lo, col_smp, snap_all} !== 5'b0) begin
      n_bad++;
      $display("FAIL R1: got busy=%b done=%b rs=%b tx=%b exp all zero", busy, done, row_sel, tx);
    end
    n_chk++;
    if (row_idx !== '0 || sub_idx !== '0) begin
      n_bad++;
      $display("FAIL R1: got idx=%0d/%0d exp 0/0", row_idx, sub_idx);
    end
    run_frame(1'b0, 2, 3, 2, 1'b0, "R3 R4 R5 R6 R7 R8");
    run_frame(1'b0, 0, 0, 0, 1'b0, "R3 zero-length");
    run_frame(1'b1, 1, 4, 2, 1'b0, "R9");
    run_frame(1'b0, 1, 2, 3, 1'b1, "R2 R10");
    run_frame(1'b1, 3, 0, 1, 1'b1, "R9 R10");
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule